// File: doc/BRIEF.md
# Dual-View General Register File

This block holds sixty-four 64-bit integer registers in a single storage array. Two separate access views reach that array. The wide view sees every register at full width. The narrow view sees only the lowest sixteen registers, and only as 32-bit values.

Each view has two combinational read ports and one write port that commits on the clock edge. The top register of the wide view is wired to zero. When the narrow view writes, it sign-extends its 32-bit value into the whole 64-bit register, and the wide view sees the result at once. When both views write the same register in one cycle, the wide view wins.

Reset is synchronous and active low, and it clears every register. A read in the same cycle as a write returns the value held before that write.

Top module: `dual_view_regfile`

## Requirements
- R1: A wide read port with an index from 0 to 62 returns, in the same cycle, the full 64-bit value held in that register.
- R2: A wide read port with index 63 returns zero, whatever has been written to index 63.
- R3: A wide write to index 63 is dropped. No register changes, and index 63 still reads zero.
- R4: A wide write with its enable high stores all 64 data bits into the indexed register (0 to 62) at the next rising clock edge.
- R5: A narrow read port takes a 4-bit index (0 to 15). It returns bits 31:0 of that register in bits 31:0 of its 64-bit output, with bits 63:32 zero.
- R6: A narrow write stores its 32-bit value, with bit 31 copied into bits 63:32, into register 0 to 15 at the next rising edge. The wide view can read the result.
- R7: When wide and narrow writes target the same register in one cycle, the register takes the wide data. When they target different registers, both writes take effect.
- R8: While rst_n is low at a rising edge, every register is cleared to zero.
- R9: During a write cycle, a read of the register being written returns its old value until the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_ra_idx | input | 6 | Wide read port A index |
| wide_ra_data | output | 64 | Wide read port A data |
| wide_rb_idx | input | 6 | Wide read port B index |
| wide_rb_data | output | 64 | Wide read port B data |
| wide_we | input | 1 | Wide write enable |
| wide_w_idx | input | 6 | Wide write index |
| wide_w_data | input | 64 | Wide write data |
| nar_ra_idx | input | 4 | Narrow read port A index |
| nar_ra_data | output | 64 | Narrow read port A data (upper half zero) |
| nar_rb_idx | input | 4 | Narrow read port B index |
| nar_rb_data | output | 64 | Narrow read port B data (upper half zero) |
| nar_we | input | 1 | Narrow write enable |
| nar_w_idx | input | 4 | Narrow write index |
| nar_w_data | input | 32 | Narrow write data |

## Verification
A corrupted register shows up at any read port the cycle after the faulty write. It stays visible until that register is written again, so every write is read back through both views. A fault in the collision merge would leave the narrow value in a register that the wide view had also written. A fault in extension would show wrong upper bits on a wide read of a narrow-written register. A leak into the zero register would appear only as a nonzero wide read of index 63, so that index is read right after a write to it.

// File: rtl/dvrf_pkg.sv
// Package: shared sizes for the dual-view register file.
// Assumes the narrow view covers the lowest NAR_REGS entries of the array.
package dvrf_pkg;
    parameter int REG_W    = 64;
    parameter int NUM_REGS = 64;
    parameter int NAR_W    = 32;
    parameter int NAR_REGS = 16;

    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int NIDX_W   = $clog2(NAR_REGS);
    localparam int ZERO_IDX = NUM_REGS - 1;

    typedef logic [REG_W-1:0] reg_word_t;
    typedef logic [IDX_W-1:0] reg_idx_t;

    // One write that is ready to commit to the storage array.
    typedef struct packed {
        logic      en;
        reg_idx_t  idx;
        reg_word_t data;
    } commit_t;
endpackage

// File: rtl/dvrf_write_merge.sv
// Module: dvrf_write_merge
// Turns the wide and narrow write requests into two commit channels.
// Channel A carries the wide write and channel B the narrow write.
// Assumes both requests are sampled in the same cycle. Channel B is
// sign-extended, and it is dropped when it collides with a live wide write.
module dvrf_write_merge
    import dvrf_pkg::*;
(
    input  logic              wide_we,
    input  reg_idx_t          wide_idx,
    input  reg_word_t         wide_data,
    input  logic              nar_we,
    input  logic [NIDX_W-1:0] nar_idx,
    input  logic [NAR_W-1:0]  nar_data,
    output commit_t           chan_a,
    output commit_t           chan_b
);
    localparam int PAD_W = IDX_W - NIDX_W;
    localparam int EXT_W = REG_W - NAR_W;

    reg_idx_t nar_idx_full;
    logic     wide_live;

    // Widen the narrow index onto the shared index space.
    always_comb nar_idx_full = {{PAD_W{1'b0}}, nar_idx};

    // A wide write to the zero register is discarded here.
    always_comb wide_live = wide_we && (wide_idx != reg_idx_t'(ZERO_IDX));

    // Channel A: the wide view, with full-width data.
    always_comb begin
        chan_a.en   = wide_live;
        chan_a.idx  = wide_idx;
        chan_a.data = wide_data;
    end

    // Channel B: the narrow view, sign-extended; the wide view wins a collision.
    always_comb begin
        chan_b.en   = nar_we && !(wide_live && (wide_idx == nar_idx_full));
        chan_b.idx  = nar_idx_full;
        chan_b.data = {{EXT_W{nar_data[NAR_W-1]}}, nar_data};
    end
endmodule

// File: rtl/dvrf_storage.sv
// Module: dvrf_storage
// The storage array, with two independent write channels per cycle.
// Assumes the two channels never target the same entry. The top entry
// is never written and is held at zero. Reset is synchronous, active low.
module dvrf_storage
    import dvrf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  commit_t   chan_a,
    input  commit_t   chan_b,
    output reg_word_t mem [NUM_REGS]
);
    genvar k;
    generate
        for (k = 0; k < NUM_REGS; k++) begin : g_entry
            if (k == ZERO_IDX) begin : g_zero
                // Hold the hardwired-zero entry at zero.
                always_comb mem[k] = '0;
            end else begin : g_live
                // Update one entry from whichever channel selects it.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        mem[k] <= '0;
                    else if (chan_a.en && chan_a.idx == reg_idx_t'(k))
                        mem[k] <= chan_a.data;
                    else if (chan_b.en && chan_b.idx == reg_idx_t'(k))
                        mem[k] <= chan_b.data;
                end
            end
        end
    endgenerate

    // The merge must never hand both channels the same entry.
    assert_chan_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_a.en && chan_b.en) |-> (chan_a.idx != chan_b.idx));

    // The wide channel commits its whole word.
    assert_wide_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chan_a.en |=> (mem[$past(chan_a.idx)] == $past(chan_a.data)));

    // The narrow channel commits its extended word.
    assert_nar_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chan_b.en |=> (mem[$past(chan_b.idx)] == $past(chan_b.data)));

    // The zero entry never holds anything else.
    assert_zero_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem[ZERO_IDX] == '0);

    // After a reset edge the lowest and highest live entries are clear.
    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (mem[0] == '0 && mem[ZERO_IDX-1] == '0));
endmodule

// File: rtl/dvrf_read_port.sv
// Module: dvrf_read_port
// One combinational read port. NARROW picks the variant.
// The wide variant forces the zero index to read zero. The narrow
// variant returns the low half, zero-extended. Assumes the caller
// pads narrow indices into the shared index space.
module dvrf_read_port
    import dvrf_pkg::*;
#(
    parameter bit NARROW = 1'b0
) (
    input  reg_word_t mem [NUM_REGS],
    input  reg_idx_t  idx,
    output reg_word_t data
);
    generate
        if (NARROW) begin : g_narrow
            // Return the low half of the register, upper half zero.
            always_comb data = {{(REG_W-NAR_W){1'b0}}, mem[idx][NAR_W-1:0]};
        end else begin : g_wide
            // Return the full register, or zero for the hardwired index.
            always_comb data = (idx == reg_idx_t'(ZERO_IDX)) ? '0 : mem[idx];
        end
    endgenerate
endmodule

// File: rtl/dual_view_regfile.sv
// Module: dual_view_regfile
// Top level: one 64x64 register file reached through a wide view and a
// 32-bit narrow view that covers the first sixteen registers. Each view
// has two read ports and one write port. Assumes a single clock and a
// synchronous active-low reset.
module dual_view_regfile
    import dvrf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    wide_ra_idx,
    output logic [REG_W-1:0]    wide_ra_data,
    input  logic [IDX_W-1:0]    wide_rb_idx,
    output logic [REG_W-1:0]    wide_rb_data,
    input  logic                wide_we,
    input  logic [IDX_W-1:0]    wide_w_idx,
    input  logic [REG_W-1:0]    wide_w_data,
    input  logic [NIDX_W-1:0]   nar_ra_idx,
    output logic [REG_W-1:0]    nar_ra_data,
    input  logic [NIDX_W-1:0]   nar_rb_idx,
    output logic [REG_W-1:0]    nar_rb_data,
    input  logic                nar_we,
    input  logic [NIDX_W-1:0]   nar_w_idx,
    input  logic [NAR_W-1:0]    nar_w_data
);
    localparam int PAD_W = IDX_W - NIDX_W;

    commit_t   chan_a;
    commit_t   chan_b;
    reg_word_t mem [NUM_REGS];
    reg_idx_t  rd_idx   [4];
    reg_word_t rd_data  [4];

    // Gather the four read indices; narrow indices are padded.
    always_comb begin
        rd_idx[0] = wide_ra_idx;
        rd_idx[1] = wide_rb_idx;
        rd_idx[2] = {{PAD_W{1'b0}}, nar_ra_idx};
        rd_idx[3] = {{PAD_W{1'b0}}, nar_rb_idx};
    end

    dvrf_write_merge u_merge (
        .wide_we   (wide_we),
        .wide_idx  (wide_w_idx),
        .wide_data (wide_w_data),
        .nar_we    (nar_we),
        .nar_idx   (nar_w_idx),
        .nar_data  (nar_w_data),
        .chan_a    (chan_a),
        .chan_b    (chan_b)
    );

    dvrf_storage u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .chan_a (chan_a),
        .chan_b (chan_b),
        .mem    (mem)
    );

    genvar p;
    generate
        for (p = 0; p < 4; p++) begin : g_rd
            dvrf_read_port #(.NARROW(p >= 2)) u_rd (
                .mem  (mem),
                .idx  (rd_idx[p]),
                .data (rd_data[p])
            );
        end
    endgenerate

    // Drive the read outputs from the port array.
    always_comb begin
        wide_ra_data = rd_data[0];
        wide_rb_data = rd_data[1];
        nar_ra_data  = rd_data[2];
        nar_rb_data  = rd_data[3];
    end

    // The narrow outputs never carry upper-half bits.
    assert_nar_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (nar_ra_data[REG_W-1:NAR_W] == '0) && (nar_rb_data[REG_W-1:NAR_W] == '0));

    // The wide view of the zero index reads zero.
    assert_zero_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_ra_idx == reg_idx_t'(ZERO_IDX)) |-> (wide_ra_data == '0));

    // A collision leaves the wide data in the register.
    assert_wide_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_we && nar_we && wide_w_idx == {{PAD_W{1'b0}}, nar_w_idx}
         && wide_ra_idx == wide_w_idx && $stable(wide_ra_idx))
        |=> (wide_ra_data == $past(wide_w_data)));
endmodule

// File: tb/test_dual_view_regfile.sv
module test_dual_view_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  wide_ra_idx = '0, wide_rb_idx = '0, wide_w_idx = '0;
    logic [63:0] wide_ra_data, wide_rb_data, wide_w_data = '0;
    logic        wide_we = 1'b0, nar_we = 1'b0;
    logic [3:0]  nar_ra_idx = '0, nar_rb_idx = '0, nar_w_idx = '0;
    logic [63:0] nar_ra_data, nar_rb_data;
    logic [31:0] nar_w_data = '0;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [63:0] model [64];

    always #10 clk = ~clk;  // 50 MHz

    dual_view_regfile i_dual_view_regfile (
        .clk(clk), .rst_n(rst_n),
        .wide_ra_idx(wide_ra_idx), .wide_ra_data(wide_ra_data),
        .wide_rb_idx(wide_rb_idx), .wide_rb_data(wide_rb_data),
        .wide_we(wide_we), .wide_w_idx(wide_w_idx), .wide_w_data(wide_w_data),
        .nar_ra_idx(nar_ra_idx), .nar_ra_data(nar_ra_data),
        .nar_rb_idx(nar_rb_idx), .nar_rb_data(nar_rb_data),
        .nar_we(nar_we), .nar_w_idx(nar_w_idx), .nar_w_data(nar_w_data)
    );

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One clock with the given write requests; updates the model per R3/R4/R6/R7.
    task automatic do_write(bit we_w, logic [5:0] iw, logic [63:0] dw,
                            bit we_n, logic [3:0] in_, logic [31:0] dn);
        @(negedge clk);
        wide_we = we_w; wide_w_idx = iw; wide_w_data = dw;
        nar_we = we_n; nar_w_idx = in_; nar_w_data = dn;
        @(posedge clk);
        if (we_n && !(we_w && iw != 6'd63 && iw == {2'b0, in_}))
            model[in_] = {{32{dn[31]}}, dn};
        if (we_w && iw != 6'd63) model[iw] = dw;
        @(negedge clk);
        wide_we = 1'b0; nar_we = 1'b0;
    endtask

    task automatic read_wide(string req, int idx);
        wide_ra_idx = 6'(idx); wide_rb_idx = 6'(idx);
        #1;
        check(req, wide_ra_data, (idx == 63) ? 64'd0 : model[idx]);
        check(req, wide_rb_data, (idx == 63) ? 64'd0 : model[idx]);
    endtask

    task automatic read_nar(string req, int idx);
        nar_ra_idx = 4'(idx); nar_rb_idx = 4'(idx);
        #1;
        check(req, nar_ra_data, {32'd0, model[idx][31:0]});
        check(req, nar_rb_data, {32'd0, model[idx][31:0]});
    endtask

    task automatic apply_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 64; i++) model[i] = '0;
    endtask

    task automatic t_reset_state();
        apply_reset();
        for (int i = 0; i < 64; i++) read_wide("R8 reset", i);
    endtask

    task automatic t_wide_writes();
        do_write(1, 6'd0, 64'h0123_4567_89AB_CDEF, 0, 0, 0);
        do_write(1, 6'd17, 64'hFFFF_0000_AAAA_5555, 0, 0, 0);
        do_write(1, 6'd62, 64'h8000_0000_0000_0001, 0, 0, 0);
        do_write(1, 6'd15, 64'hDEAD_BEEF_CAFE_F00D, 0, 0, 0);
        foreach (model[i]) read_wide("R1/R4 wide", i);
    endtask

    task automatic t_zero_register();
        do_write(1, 6'd63, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0);
        read_wide("R2 zero read", 63);
        for (int i = 0; i < 63; i++) read_wide("R3 no effect", i);
    endtask

    task automatic t_narrow();
        read_nar("R5 narrow low half", 15);
        do_write(0, 0, 0, 1, 4'd3, 32'h8000_1234);
        do_write(0, 0, 0, 1, 4'd9, 32'h7FFF_0000);
        read_wide("R6 sign ext neg", 3);
        check("R6 neg value", wide_ra_data, 64'hFFFF_FFFF_8000_1234);
        read_wide("R6 sign ext pos", 9);
        check("R6 pos value", wide_ra_data, 64'h0000_0000_7FFF_0000);
        read_nar("R5 narrow read", 3);
        check("R5 zero ext", nar_ra_data, 64'h0000_0000_8000_1234);
        for (int i = 0; i < 16; i++) read_nar("R5 sweep", i);
    endtask

    task automatic t_collide();
        do_write(1, 6'd5, 64'h1111_2222_3333_4444, 1, 4'd5, 32'hF0F0_F0F0);
        read_wide("R7 wide wins", 5);
        check("R7 wins value", wide_ra_data, 64'h1111_2222_3333_4444);
        do_write(1, 6'd20, 64'hAAAA_BBBB_CCCC_DDDD, 1, 4'd6, 32'h8765_4321);
        read_wide("R7 both wide", 20);
        read_wide("R7 both narrow", 6);
        check("R7 narrow value", wide_ra_data, 64'hFFFF_FFFF_8765_4321);
        do_write(1, 6'd63, 64'h5, 1, 4'd7, 32'h0000_0042);
        read_wide("R7 zero-idx no block", 7);
    endtask

    task automatic t_old_value();
        @(negedge clk);
        wide_ra_idx = 6'd17; nar_ra_idx = 4'd9;
        wide_we = 1'b1; wide_w_idx = 6'd17; wide_w_data = 64'h0BAD_0BAD_0BAD_0BAD;
        nar_we = 1'b1; nar_w_idx = 4'd9; nar_w_data = 32'h1357_9BDF;
        #5;
        check("R9 old wide", wide_ra_data, model[17]);
        check("R9 old narrow", nar_ra_data, {32'd0, model[9][31:0]});
        @(posedge clk);
        model[17] = 64'h0BAD_0BAD_0BAD_0BAD;
        model[9]  = 64'h0000_0000_1357_9BDF;
        @(negedge clk);
        wide_we = 1'b0; nar_we = 1'b0;
        read_wide("R9 new wide", 17);
        read_nar("R9 new narrow", 9);
    endtask

    task automatic t_reset_again();
        do_write(1, 6'd40, 64'h7777, 1, 4'd1, 32'hFFFF_FFFF);
        apply_reset();
        read_wide("R8 clear 40", 40);
        read_wide("R8 clear 1", 1);
        read_nar("R8 narrow clear", 1);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) model[i] = '0;
        t_reset_state();
        t_wide_writes();
        t_zero_register();
        t_narrow();
        t_collide();
        t_old_value();
        t_reset_again();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule